// File: doc/BRIEF.md
# Virtual Address Translator with Associative Cache and Two-Level Table Walk

This block turns a 32-bit virtual address into a physical address for a 4 KB page size. A request carries the virtual address, the address-space tag of the current process, and the kind of access (read, write or execute). The block first searches a small fully associative translation cache. On a hit it answers at once. On a miss it walks a two-level page table in memory, starting from a table base register. It then installs the result in the cache and answers.

Every translation is checked in a fixed order. The page number is first compared against a table length limit. Then each table entry read must have its valid bit set. Finally the permission bits must allow the access. Each kind of violation returns its own fault code. The block handles one translation at a time and holds `req_ready` low until the answer is out. A flush input empties the cache in one cycle, for example when the tag space is reused.

Top module: `vtrans_unit`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_rd_en` are 0.
- R2: On a cache miss the block issues exactly two word reads. The first read goes to {ptbr, va[31:22], 2'b00}. The second goes to {E1[31:12], va[21:12], 2'b00}, where E1 is the first table entry. The answer is {E2[31:12], va[11:0]} with fault 0 and `rsp_tlb_hit` 0, where E2 is the second entry. Table entry layout: bit 0 is valid, bit 1 is read, bit 2 is write, bit 3 is execute, and bits 31:12 hold the frame.
- R3: A later request with the same tag and page number is answered from the cache. It makes no memory read, and `rsp_tlb_hit` is 1.
- R4: A cached entry matches only when its address-space tag equals `req_asid`. The same page under another tag causes a full walk.
- R5: If va[31:12] >= `ptlr`, the answer is fault code 1 (limit) with no memory read, even when the page is cached. A page number one below the limit proceeds normally.
- R6: A table entry with bit 0 clear, at either level, gives fault code 2 (invalid). An invalid first-level entry stops the walk after one read. An invalid entry is never cached, so repeating the request walks again.
- R7: The access codes are 0 for read, 1 for write and 2 for execute. Each code needs its own permission bit. Code 3 is never allowed. A violation gives fault code 3, both after a walk and on a cache hit. Any faulting answer carries `rsp_paddr` = 0.
- R8: The cache holds 8 entries, and refills fill them in round-robin order. The ninth distinct page refilled evicts the first one. The second one stays cached until the pointer comes back to it.
- R9: A one-cycle pulse on `flush` invalidates every cached entry and returns the replacement pointer to entry 0.
- R10: After a request is accepted, `req_ready` stays 0 until the cycle in which the one-cycle `rsp_valid` pulse appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all cached translations |
| ptbr | input | 20 | Frame number of the first-level table |
| ptlr | input | 20 | Page-number limit; numbers at or above it fault |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address |
| req_asid | input | 8 | Address-space tag of the requester |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | One-cycle answer strobe |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 invalid, 3 permission |
| rsp_tlb_hit | output | 1 | Answer came from the cache |
| mem_rd_en | output | 1 | Table word read strobe |
| mem_rd_addr | output | 32 | Byte address of the table word |
| mem_rd_data | input | 32 | Table word, valid the cycle after the strobe |

## Verification
Some properties are checked on every cycle:
- at most one cached entry matches a lookup;
- a flush leaves no valid entry;
- table reads are word aligned and never occur for a page number at or above the limit;
- answers are single-cycle pulses;
- faulting answers carry a zero address.

Other behaviour can only be shown by the bench's scenarios:
- the correct frame arithmetic;
- tag isolation;
- the exact number of table reads per request;
- the fault order on cached pages;
- round-robin eviction.

The bench scenarios run a scripted page table through misses, hits, faults at both table levels, the limit boundary and flushes.

// File: rtl/vt_pkg.sv
package vt_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int ENT_LG = 2;
  localparam int IDX_W  = OFF_W - ENT_LG;
  localparam int VPN_W  = VA_W - OFF_W;
  localparam int PFN_W  = VA_W - OFF_W;
  localparam int PTE_W  = 32;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_LEN  = 2'd1,
    FLT_INV  = 2'd2,
    FLT_PERM = 2'd3
  } flt_e;

  // {x, w, r} matches table entry bits 3:1
  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;
endpackage

// File: rtl/vt_tlb.sv
module vt_tlb
  import vt_pkg::*;
#(
  parameter int N      = 8,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [2:0]        lk_perm,
  input  logic              rf_en,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [2:0]        rf_perm
);
  localparam int PTR_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]      vld;
  logic [ASID_W-1:0] tag_asid [N];
  logic [VPN_W-1:0]  tag_vpn  [N];
  logic [PFN_W-1:0]  dat_pfn  [N];
  logic [2:0]        dat_perm [N];
  logic [PTR_W-1:0]  ptr;
  logic [N-1:0]      hit_vec;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = vld[i] && (tag_asid[i] == lk_asid) && (tag_vpn[i] == lk_vpn);
  end

  assign lk_hit = |hit_vec;

  always_comb begin
    lk_pfn  = '0;
    lk_perm = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) begin
        lk_pfn  = lk_pfn | dat_pfn[i];
        lk_perm = lk_perm | dat_perm[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (rf_en) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == PTR_W'(N - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_en && !flush) begin
      tag_asid[ptr] <= rf_asid;
      tag_vpn[ptr]  <= rf_vpn;
      dat_pfn[ptr]  <= rf_pfn;
      dat_perm[ptr] <= rf_perm;
    end
  end

  a_r3_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(hit_vec));

  a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (vld == '0));
endmodule

// File: rtl/vt_perm_chk.sv
module vt_perm_chk
  import vt_pkg::*;
(
  input  logic [1:0] acc,
  input  logic [2:0] perm,
  output logic       ok
);
  perm_t p;
  assign p = perm_t'(perm);

  always_comb begin
    unique case (acc_e'(acc))
      ACC_RD:  ok = p.r;
      ACC_WR:  ok = p.w;
      ACC_EX:  ok = p.x;
      default: ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/vt_walker.sv
module vt_walker
  import vt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PFN_W-1:0] base_pfn,
  input  logic [VPN_W-1:0] vpn,
  output logic             rd_en,
  output logic [VA_W-1:0]  rd_addr,
  input  logic [PTE_W-1:0] rd_data,
  output logic             done,
  output logic             ok,
  output logic [PFN_W-1:0] pfn,
  output logic [2:0]       perm
);
  typedef enum logic [2:0] {W_IDLE, W_OREQ, W_ODAT, W_IREQ, W_IDAT} wst_e;

  wst_e             st;
  logic [PFN_W-1:0] tbl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= W_IDLE;
      tbl_q <= '0;
    end else begin
      unique case (st)
        W_IDLE: if (start) st <= W_OREQ;
        W_OREQ: st <= W_ODAT;
        W_ODAT: begin
          if (rd_data[0]) begin
            tbl_q <= rd_data[PTE_W-1 -: PFN_W];
            st    <= W_IREQ;
          end else begin
            st <= W_IDLE;
          end
        end
        W_IREQ: st <= W_IDAT;
        W_IDAT: st <= W_IDLE;
        default: st <= W_IDLE;
      endcase
    end
  end

  assign rd_en   = (st == W_OREQ) || (st == W_IREQ);
  assign rd_addr = (st == W_OREQ) ? {base_pfn, vpn[VPN_W-1 -: IDX_W], {ENT_LG{1'b0}}}
                                  : {tbl_q, vpn[IDX_W-1:0], {ENT_LG{1'b0}}};
  assign done    = ((st == W_ODAT) && !rd_data[0]) || (st == W_IDAT);
  assign ok      = (st == W_IDAT) && rd_data[0];
  assign pfn     = rd_data[PTE_W-1 -: PFN_W];
  assign perm    = rd_data[3:1];

  a_r2_word_aligned: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rd_addr[ENT_LG-1:0] == '0));
endmodule

// File: rtl/vtrans_unit.sv
module vtrans_unit
  import vt_pkg::*;
#(
  parameter int TLB_N  = 8,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [19:0]       ptbr,
  input  logic [19:0]       ptlr,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_vaddr,
  input  logic [ASID_W-1:0] req_asid,
  input  logic [1:0]        req_acc,
  output logic              rsp_valid,
  output logic [31:0]       rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              rsp_tlb_hit,
  output logic              mem_rd_en,
  output logic [31:0]       mem_rd_addr,
  input  logic [31:0]       mem_rd_data
);
  typedef enum logic [1:0] {T_IDLE, T_LOOK, T_WALK} tst_e;

  tst_e              st;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;
  logic [1:0]        acc_q;
  logic [PFN_W-1:0]  base_q;
  logic [VPN_W-1:0]  lim_q;

  logic [VPN_W-1:0]  vpn;
  logic              len_bad;
  logic              t_hit;
  logic [PFN_W-1:0]  t_pfn;
  logic [2:0]        t_perm;
  logic              w_start, w_done, w_ok;
  logic [PFN_W-1:0]  w_pfn;
  logic [2:0]        w_perm;
  logic [2:0]        chk_perm;
  logic              perm_ok;
  logic              rf_en;

  assign vpn       = va_q[VA_W-1:OFF_W];
  assign len_bad   = (vpn >= lim_q);
  assign req_ready = (st == T_IDLE);
  assign w_start   = (st == T_LOOK) && !len_bad && !t_hit;
  assign rf_en     = (st == T_WALK) && w_done && w_ok;
  assign chk_perm  = (st == T_LOOK) ? t_perm : w_perm;

  vt_tlb #(.N(TLB_N), .ASID_W(ASID_W)) u_tlb (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .lk_asid (asid_q),
    .lk_vpn  (vpn),
    .lk_hit  (t_hit),
    .lk_pfn  (t_pfn),
    .lk_perm (t_perm),
    .rf_en   (rf_en),
    .rf_asid (asid_q),
    .rf_vpn  (vpn),
    .rf_pfn  (w_pfn),
    .rf_perm (w_perm)
  );

  vt_walker u_walk (
    .clk      (clk),
    .rst      (rst),
    .start    (w_start),
    .base_pfn (base_q),
    .vpn      (vpn),
    .rd_en    (mem_rd_en),
    .rd_addr  (mem_rd_addr),
    .rd_data  (mem_rd_data),
    .done     (w_done),
    .ok       (w_ok),
    .pfn      (w_pfn),
    .perm     (w_perm)
  );

  vt_perm_chk u_perm (
    .acc  (acc_q),
    .perm (chk_perm),
    .ok   (perm_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= T_IDLE;
      va_q        <= '0;
      asid_q      <= '0;
      acc_q       <= '0;
      base_q      <= '0;
      lim_q       <= '0;
      rsp_valid   <= 1'b0;
      rsp_paddr   <= '0;
      rsp_fault   <= FLT_NONE;
      rsp_tlb_hit <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st)
        T_IDLE: begin
          if (req_valid) begin
            va_q   <= req_vaddr;
            asid_q <= req_asid;
            acc_q  <= req_acc;
            base_q <= ptbr;
            lim_q  <= ptlr;
            st     <= T_LOOK;
          end
        end
        T_LOOK: begin
          if (len_bad) begin
            rsp_valid   <= 1'b1;
            rsp_fault   <= FLT_LEN;
            rsp_paddr   <= '0;
            rsp_tlb_hit <= 1'b0;
            st          <= T_IDLE;
          end else if (t_hit) begin
            rsp_valid   <= 1'b1;
            rsp_fault   <= perm_ok ? FLT_NONE : FLT_PERM;
            rsp_paddr   <= perm_ok ? {t_pfn, va_q[OFF_W-1:0]} : '0;
            rsp_tlb_hit <= 1'b1;
            st          <= T_IDLE;
          end else begin
            st <= T_WALK;
          end
        end
        T_WALK: begin
          if (w_done) begin
            rsp_valid   <= 1'b1;
            rsp_tlb_hit <= 1'b0;
            st          <= T_IDLE;
            if (!w_ok) begin
              rsp_fault <= FLT_INV;
              rsp_paddr <= '0;
            end else begin
              rsp_fault <= perm_ok ? FLT_NONE : FLT_PERM;
              rsp_paddr <= perm_ok ? {w_pfn, va_q[OFF_W-1:0]} : '0;
            end
          end
        end
        default: st <= T_IDLE;
      endcase
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r7_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && (rsp_fault != FLT_NONE)) |-> (rsp_paddr == '0));

  a_r5_no_read_over_limit: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (vpn < lim_q));
endmodule

// File: tb/sim_vtrans_unit.sv
module sim_vtrans_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic [19:0] ptbr = 20'h00001;
  logic [19:0] ptlr = 20'h01000;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic [7:0]  req_asid = '0;
  logic [1:0]  req_acc = '0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        rsp_tlb_hit;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic [31:0] mem_rd_data = '0;

  always #5 clk = ~clk;

  vtrans_unit u0 (
    .clk(clk), .rst(rst), .flush(flush), .ptbr(ptbr), .ptlr(ptlr),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_asid(req_asid), .req_acc(req_acc), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_tlb_hit(rsp_tlb_hit),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  logic [31:0] pmem [4096];
  always @(posedge clk) if (mem_rd_en) mem_rd_data <= pmem[mem_rd_addr[13:2]];

  int nchk = 0;
  int nbad = 0;

  task automatic chk(input bit good, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!good) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  flt;
    logic        hit;
    int          rd;
  } exp_t;
  exp_t  sq[$];
  string tq[$];
  int    rdc = 0;
  logic  prev_rv = 1'b0;

  // monitor: counts table reads and compares each answer with the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_rd_en) rdc++;
      if (prev_rv && rsp_valid) chk(1'b0, "R10 pulse longer than one cycle", 32'd1, 32'd0);
      if (rsp_valid) begin
        if (sq.size() == 0) begin
          chk(1'b0, "R10 unexpected answer", 32'd1, 32'd0);
        end else begin
          exp_t  e;
          string t;
          e = sq.pop_front();
          t = tq.pop_front();
          chk(rsp_paddr == e.pa, {t, " paddr"}, rsp_paddr, e.pa);
          chk(rsp_fault == e.flt, {t, " fault"}, 32'(rsp_fault), 32'(e.flt));
          chk(rsp_tlb_hit == e.hit, {t, " hit"}, 32'(rsp_tlb_hit), 32'(e.hit));
          chk(rdc == e.rd, {t, " reads"}, 32'(rdc), 32'(e.rd));
        end
        rdc = 0;
      end
      prev_rv = rsp_valid;
    end
  end

  function automatic logic [31:0] va(input int o, input int i, input int off);
    return {o[9:0], i[9:0], off[11:0]};
  endfunction

  task automatic xl(input logic [31:0] a, input logic [7:0] asid, input logic [1:0] acc,
                    input logic [31:0] epa, input logic [1:0] ef, input logic eh,
                    input int erd, input string tag);
    exp_t e;
    e.pa = epa; e.flt = ef; e.hit = eh; e.rd = erd;
    sq.push_back(e);
    tq.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = a;
    req_asid  = asid;
    req_acc   = acc;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R10 busy after accept", 32'(req_ready), 32'd0);
    while (sq.size() != 0) @(negedge clk);
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  initial begin
    for (int k = 0; k < 4096; k++) pmem[k] = '0;
    pmem[1024] = 32'h0000_2001;
    pmem[1025] = 32'h0000_3001;
    pmem[1026] = 32'h0000_3000;
    for (int i = 0; i < 16; i++) pmem[2048 + i] = {20'(32'h100 + i), 12'h00F};
    pmem[2048 + 20] = {20'h200, 12'h00E};
    pmem[2048 + 21] = {20'h215, 12'h003};
    pmem[2048 + 22] = {20'h316, 12'h009};
    pmem[3072 + 5]  = {20'h777, 12'h007};

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_rd_en == 1'b0, "R1 mem_rd_en", 32'(mem_rd_en), 32'd0);

    xl(va(0, 3, 12'hABC), 8'd5, 2'd0, {20'h103, 12'hABC}, 2'd0, 1'b0, 2, "R2 miss walk");
    xl(va(0, 3, 12'hABC), 8'd5, 2'd0, {20'h103, 12'hABC}, 2'd0, 1'b1, 0, "R3 hit");
    xl(va(0, 3, 12'h123), 8'd6, 2'd0, {20'h103, 12'h123}, 2'd0, 1'b0, 2, "R4 other tag misses");
    xl(va(0, 3, 12'h123), 8'd6, 2'd0, {20'h103, 12'h123}, 2'd0, 1'b1, 0, "R4 other tag cached");
    xl(va(0, 3, 12'h010), 8'd5, 2'd1, {20'h103, 12'h010}, 2'd0, 1'b1, 0, "R3 write hit");

    xl(va(0, 21, 12'h010), 8'd5, 2'd1, 32'h0, 2'd3, 1'b0, 2, "R7 write to read-only walk");
    xl(va(0, 21, 12'h010), 8'd5, 2'd0, {20'h215, 12'h010}, 2'd0, 1'b1, 0, "R7 read of read-only hit");
    xl(va(0, 21, 12'h010), 8'd5, 2'd2, 32'h0, 2'd3, 1'b1, 0, "R7 exec of read-only hit");
    xl(va(0, 22, 12'h004), 8'd5, 2'd2, {20'h316, 12'h004}, 2'd0, 1'b0, 2, "R7 exec-only walk");
    xl(va(0, 22, 12'h004), 8'd5, 2'd0, 32'h0, 2'd3, 1'b1, 0, "R7 read of exec-only");
    xl(va(0, 3, 12'h000), 8'd5, 2'd3, 32'h0, 2'd3, 1'b1, 0, "R7 code 3 refused");

    xl(va(0, 20, 12'h000), 8'd5, 2'd0, 32'h0, 2'd2, 1'b0, 2, "R6 invalid second level");
    xl(va(0, 20, 12'h000), 8'd5, 2'd0, 32'h0, 2'd2, 1'b0, 2, "R6 invalid not cached");
    xl(va(2, 0, 12'h000), 8'd5, 2'd0, 32'h0, 2'd2, 1'b0, 1, "R6 invalid first level");

    xl(va(4, 0, 12'h000), 8'd5, 2'd0, 32'h0, 2'd1, 1'b0, 0, "R5 over limit");
    xl(va(3, 1023, 12'h000), 8'd5, 2'd0, 32'h0, 2'd2, 1'b0, 1, "R5 one below limit walks");
    ptlr = 20'h00003;
    xl(va(0, 3, 12'hABC), 8'd5, 2'd0, 32'h0, 2'd1, 1'b0, 0, "R5 limit beats cached page");
    xl(va(0, 2, 12'h008), 8'd5, 2'd0, {20'h102, 12'h008}, 2'd0, 1'b0, 2, "R5 below limit");
    ptlr = 20'h01000;

    xl(va(1, 5, 12'h044), 8'd5, 2'd0, {20'h777, 12'h044}, 2'd0, 1'b0, 2, "R2 second inner table");
    xl(va(1, 5, 12'h048), 8'd5, 2'd1, {20'h777, 12'h048}, 2'd0, 1'b1, 0, "R3 write hit rw page");
    xl(va(1, 5, 12'h048), 8'd5, 2'd2, 32'h0, 2'd3, 1'b1, 0, "R7 exec of rw page");

    do_flush();
    xl(va(0, 3, 12'hABC), 8'd5, 2'd0, {20'h103, 12'hABC}, 2'd0, 1'b0, 2, "R9 miss after flush");

    do_flush();
    for (int p = 0; p < 9; p++)
      xl(va(0, p, 12'h000), 8'd5, 2'd0, {20'(32'h100 + p), 12'h000}, 2'd0, 1'b0, 2, "R8 fill");
    xl(va(0, 1, 12'h000), 8'd5, 2'd0, {20'h101, 12'h000}, 2'd0, 1'b1, 0, "R8 second entry kept");
    xl(va(0, 0, 12'h000), 8'd5, 2'd0, {20'h100, 12'h000}, 2'd0, 1'b0, 2, "R8 first entry evicted");
    xl(va(0, 1, 12'h000), 8'd5, 2'd0, {20'h101, 12'h000}, 2'd0, 1'b0, 2, "R8 pointer reached second");

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++;
    nbad++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule